// File: doc/BRIEF.md
# ATA Task-File Register and Status Unit

This block is the register front end of a storage device that sits on an ATA-style parallel host interface. The host selects either the command block (eight byte-wide locations plus a 16-bit data port) or the control block, presents a three-bit offset, and strobes a read or a write. The unit holds the task-file registers, presents the 28-bit logical block address that they encode, tracks the busy and ready status bits, and drives an interrupt line toward the host.

A write to the command location hands the command code to a separate command engine through a one-cycle start pulse and marks the device busy. When that engine reports completion, the unit loads the ready pattern into status and, unless the host has masked interrupts, raises the interrupt. The interrupt stays up until the host reads the primary status location. Reading the alternate status location, in the control block, leaves it untouched. A soft-reset bit in device control holds the unit busy and, when released, returns the task file to its power-on contents.

The unit answers only when the device bit of the drive/head register names its own configured device number. The other device on the cable is then addressed, and this unit stays silent.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, status reads 0x50, sector count and sector number read 0x01, data, features, both cylinder registers and drive/head read zero, and irq, soft_rst and int_disable are low.
- R2: Command-block offsets map as follows: 0 is the 16-bit data register, 1 reads the error register (always 0x00) and writes features, 2 is sector count, 3 is sector number, 4 is cylinder low, 5 is cylinder high, 6 is drive/head, and 7 reads status and writes command. Byte registers keep wdata[7:0] and read back zero-extended.
- R3: lba equals {drive/head[3:0], cylinder high, cylinder low, sector number}, and lba_mode follows drive/head bit 6. Both take the new value in the cycle after the write.
- R4: When drive/head bit 4 differs from DEV_ID, every read returns 0 and writes are ignored. The exceptions are drive/head writes and device-control writes, which are always taken.
- R5: A command write (offset 7) while BSY (status bit 7) is clear sets status to 0x80. In the following cycle it also asserts cmd_start for exactly one cycle, with cmd_code equal to wdata[7:0]. A command write while BSY is set is ignored.
- R6: cmd_done while BSY is set loads status with 0x50 (ready and seek-complete) in the next cycle. cmd_done while BSY is clear has no effect.
- R7: A completion raises irq in the next cycle only if int_disable is low. Otherwise irq stays low.
- R8: A read of status at command offset 7 clears irq in the next cycle. A read of alternate status at control offset 2 leaves irq unchanged. A completion in the same cycle takes precedence over the clear.
- R9: A control-block write to offset 2 loads soft_rst from wdata bit 2 and int_disable from wdata bit 1, visible in the next cycle.
- R10: While soft_rst is set, status reads 0x80, irq is low and cmd_done is ignored. A device-control write that clears the bit returns every task-file register to its R1 value and sets status to 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_cmd | input | 1 | Command-block select |
| cs_ctl | input | 1 | Control-block select |
| addr | input | 3 | Register offset within the selected block |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from the current offset |
| cmd_done | input | 1 | Completion from the command engine |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_code | output | 8 | Command code captured on the last accepted command write |
| irq | output | 1 | Interrupt request to the host |
| soft_rst | output | 1 | Soft-reset bit of device control |
| int_disable | output | 1 | Interrupt-disable bit of device control |
| lba | output | 28 | Logical block address from the task file |
| lba_mode | output | 1 | LBA addressing selected in drive/head |

## Verification
Read data is combinational, so it is due in the same cycle the read strobe is driven. Every register write, command acceptance, completion, status-read clear and device-control change becomes visible one cycle after its strobe. cmd_start must be high one cycle after the command write and low again the cycle after that. The driver tags each expected value with the absolute cycle in which it is due, and the monitor compares only in that cycle, at the falling clock edge, so that both the one-cycle latency and the one-cycle pulse width are checked exactly.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    localparam int TF_ADDR_W = 3;
    localparam int TF_DATA_W = 16;
    localparam int TF_REG_W  = 8;
    localparam int TF_LBA_W  = 4 + 3 * TF_REG_W;

    // command-block offsets
    localparam logic [TF_ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [TF_ADDR_W-1:0] OFS_EFEAT = 3'd1;
    localparam logic [TF_ADDR_W-1:0] OFS_SCNT  = 3'd2;
    localparam logic [TF_ADDR_W-1:0] OFS_SNUM  = 3'd3;
    localparam logic [TF_ADDR_W-1:0] OFS_CYLLO = 3'd4;
    localparam logic [TF_ADDR_W-1:0] OFS_CYLHI = 3'd5;
    localparam logic [TF_ADDR_W-1:0] OFS_DRVHD = 3'd6;
    localparam logic [TF_ADDR_W-1:0] OFS_STCMD = 3'd7;
    // control-block offset
    localparam logic [TF_ADDR_W-1:0] OFS_DCTL  = 3'd2;

    // status bit positions
    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_SEEK = 4;
    localparam logic [TF_REG_W-1:0] ST_READY = TF_REG_W'((1 << ST_DRDY) | (1 << ST_SEEK));
    localparam logic [TF_REG_W-1:0] ST_BUSY  = TF_REG_W'(1 << ST_BSY);

    // device-control and drive/head bit positions
    localparam int DC_SRST = 2;
    localparam int DC_NIEN = 1;
    localparam int DH_DEV  = 4;
    localparam int DH_LBA  = 6;

    typedef struct packed {
        logic data;
        logic feat;
        logic scnt;
        logic snum;
        logic cyllo;
        logic cylhi;
        logic drvhd;
        logic cmd;
        logic devctl;
    } tfr_wr_t;

    typedef enum logic [3:0] {
        RS_NONE, RS_DATA, RS_ERROR, RS_SCNT, RS_SNUM,
        RS_CYLLO, RS_CYLHI, RS_DRVHD, RS_STATUS, RS_ALTST
    } tfr_rsel_t;

    typedef struct packed {
        logic [TF_DATA_W-1:0] data;
        logic [TF_REG_W-1:0]  feat;
        logic [TF_REG_W-1:0]  scnt;
        logic [TF_REG_W-1:0]  snum;
        logic [TF_REG_W-1:0]  cyllo;
        logic [TF_REG_W-1:0]  cylhi;
        logic [TF_REG_W-1:0]  drvhd;
    } tfr_regs_t;

    localparam tfr_regs_t TFR_INIT = '{
        data: '0, feat: '0, scnt: TF_REG_W'(1), snum: TF_REG_W'(1),
        cyllo: '0, cylhi: '0, drvhd: '0
    };

    function automatic logic [TF_LBA_W-1:0] make_lba(input tfr_regs_t r);
        return {r.drvhd[3:0], r.cylhi, r.cyllo, r.snum};
    endfunction

endpackage

// File: rtl/tfr_decode.sv
module tfr_decode
    import tfr_pkg::*;
#(
    parameter int DEV_ID = 0
) (
    input  logic                 cs_cmd,
    input  logic                 cs_ctl,
    input  logic [TF_ADDR_W-1:0] addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic                 drvhd_dev,
    output tfr_wr_t              wr,
    output tfr_rsel_t            rsel,
    output logic                 stat_rd,
    output logic                 dev_match
);

    localparam logic MY_DEV = DEV_ID[0];

    always_comb begin
        dev_match = (drvhd_dev == MY_DEV);
        wr        = '0;
        rsel      = RS_NONE;

        if (cs_cmd && wr_en) begin
            if (addr == OFS_DRVHD) begin
                wr.drvhd = 1'b1;
            end else if (dev_match) begin
                unique case (addr)
                    OFS_DATA:  wr.data  = 1'b1;
                    OFS_EFEAT: wr.feat  = 1'b1;
                    OFS_SCNT:  wr.scnt  = 1'b1;
                    OFS_SNUM:  wr.snum  = 1'b1;
                    OFS_CYLLO: wr.cyllo = 1'b1;
                    OFS_CYLHI: wr.cylhi = 1'b1;
                    OFS_STCMD: wr.cmd   = 1'b1;
                    default:   wr       = '0;
                endcase
            end
        end else if (cs_ctl && wr_en && addr == OFS_DCTL) begin
            wr.devctl = 1'b1;
        end

        if (rd_en && dev_match) begin
            if (cs_cmd) begin
                unique case (addr)
                    OFS_DATA:  rsel = RS_DATA;
                    OFS_EFEAT: rsel = RS_ERROR;
                    OFS_SCNT:  rsel = RS_SCNT;
                    OFS_SNUM:  rsel = RS_SNUM;
                    OFS_CYLLO: rsel = RS_CYLLO;
                    OFS_CYLHI: rsel = RS_CYLHI;
                    OFS_DRVHD: rsel = RS_DRVHD;
                    default:   rsel = RS_STATUS;
                endcase
            end else if (cs_ctl && addr == OFS_DCTL) begin
                rsel = RS_ALTST;
            end
        end

        stat_rd = (rsel == RS_STATUS);
    end

endmodule

// File: rtl/tfr_regfile.sv
module tfr_regfile
    import tfr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  tfr_wr_t              wr,
    input  logic [TF_DATA_W-1:0] wdata,
    input  logic                 soft_clear,
    output tfr_regs_t            regs,
    output logic [TF_LBA_W-1:0]  lba,
    output logic                 lba_mode
);

    logic [TF_REG_W-1:0] wbyte;
    assign wbyte = wdata[TF_REG_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || soft_clear) begin
            regs <= TFR_INIT;
        end else begin
            if (wr.data)  regs.data  <= wdata;
            if (wr.feat)  regs.feat  <= wbyte;
            if (wr.scnt)  regs.scnt  <= wbyte;
            if (wr.snum)  regs.snum  <= wbyte;
            if (wr.cyllo) regs.cyllo <= wbyte;
            if (wr.cylhi) regs.cylhi <= wbyte;
            if (wr.drvhd) regs.drvhd <= wbyte;
        end
    end

    assign lba      = make_lba(regs);
    assign lba_mode = regs.drvhd[DH_LBA];

    AST_LBA_TRACKS_SNUM: assert property (@(posedge clk) disable iff (rst)
        (wr.snum && !soft_clear) |=> (lba[TF_REG_W-1:0] == $past(wbyte))) // R3
        else $error("sector number write not reflected in lba");

endmodule

// File: rtl/tfr_status.sv
module tfr_status
    import tfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_cmd,
    input  logic                wr_devctl,
    input  logic [TF_REG_W-1:0] wbyte,
    input  logic                stat_rd,
    input  logic                cmd_done,
    output logic [TF_REG_W-1:0] status,
    output logic                irq,
    output logic                srst_q,
    output logic                nien_q,
    output logic                cmd_start,
    output logic [TF_REG_W-1:0] cmd_code,
    output logic                soft_clear
);

    logic busy;
    assign busy       = status[ST_BSY];
    assign soft_clear = wr_devctl && srst_q && !wbyte[DC_SRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            status    <= ST_READY;
            irq       <= 1'b0;
            srst_q    <= 1'b0;
            nien_q    <= 1'b0;
            cmd_start <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_start <= 1'b0;
            if (stat_rd) irq <= 1'b0;
            if (wr_devctl) begin
                srst_q <= wbyte[DC_SRST];
                nien_q <= wbyte[DC_NIEN];
            end

            if (wr_devctl && wbyte[DC_SRST]) begin
                status <= ST_BUSY;
                irq    <= 1'b0;
            end else if (soft_clear) begin
                status <= ST_READY;
                irq    <= 1'b0;
            end else if (srst_q) begin
                status <= ST_BUSY;
            end else if (wr_cmd && !busy) begin
                status    <= ST_BUSY;
                cmd_start <= 1'b1;
                cmd_code  <= wbyte;
            end else if (cmd_done && busy) begin
                status <= ST_READY;
                if (!nien_q) irq <= 1'b1;
            end
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start) // R5
        else $error("cmd_start longer than one cycle");

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> busy) // R5
        else $error("cmd_start without BSY");

    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && busy && !srst_q && !wr_devctl) |=> (status == ST_READY)) // R6
        else $error("completion did not load ready status");

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !$past(nien_q)) // R7
        else $error("irq raised while disabled");

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !(cmd_done && busy)) |=> !irq) // R8
        else $error("status read did not clear irq");

    AST_SRST_BUSY: assert property (@(posedge clk) disable iff (rst)
        (srst_q && !(wr_devctl && !wbyte[DC_SRST])) |=> busy) // R10
        else $error("BSY dropped during soft reset");

endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import tfr_pkg::*;
#(
    parameter int DEV_ID = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_cmd,
    input  logic        cs_ctl,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        cmd_done,
    output logic        cmd_start,
    output logic [7:0]  cmd_code,
    output logic        irq,
    output logic        soft_rst,
    output logic        int_disable,
    output logic [27:0] lba,
    output logic        lba_mode
);

    localparam logic [TF_REG_W-1:0] ERR_VALUE = '0;

    tfr_wr_t             wr;
    tfr_rsel_t           rsel;
    logic                stat_rd;
    logic                dev_match;
    tfr_regs_t           regs;
    logic [TF_REG_W-1:0] status;
    logic                soft_clear;

    tfr_decode #(.DEV_ID(DEV_ID)) u_decode (
        .cs_cmd    (cs_cmd),
        .cs_ctl    (cs_ctl),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .drvhd_dev (regs.drvhd[DH_DEV]),
        .wr        (wr),
        .rsel      (rsel),
        .stat_rd   (stat_rd),
        .dev_match (dev_match)
    );

    tfr_regfile u_regfile (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .wdata      (wdata),
        .soft_clear (soft_clear),
        .regs       (regs),
        .lba        (lba),
        .lba_mode   (lba_mode)
    );

    tfr_status u_status (
        .clk        (clk),
        .rst        (rst),
        .wr_cmd     (wr.cmd),
        .wr_devctl  (wr.devctl),
        .wbyte      (wdata[TF_REG_W-1:0]),
        .stat_rd    (stat_rd),
        .cmd_done   (cmd_done),
        .status     (status),
        .irq        (irq),
        .srst_q     (soft_rst),
        .nien_q     (int_disable),
        .cmd_start  (cmd_start),
        .cmd_code   (cmd_code),
        .soft_clear (soft_clear)
    );

    always_comb begin
        unique case (rsel)
            RS_DATA:   rdata = regs.data;
            RS_ERROR:  rdata = TF_DATA_W'(ERR_VALUE);
            RS_SCNT:   rdata = TF_DATA_W'(regs.scnt);
            RS_SNUM:   rdata = TF_DATA_W'(regs.snum);
            RS_CYLLO:  rdata = TF_DATA_W'(regs.cyllo);
            RS_CYLHI:  rdata = TF_DATA_W'(regs.cylhi);
            RS_DRVHD:  rdata = TF_DATA_W'(regs.drvhd);
            RS_STATUS,
            RS_ALTST:  rdata = TF_DATA_W'(status);
            default:   rdata = '0;
        endcase
    end

    AST_UNSELECTED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !dev_match |-> (rdata == '0 && !wr.cmd)) // R4
        else $error("unselected device responded");

endmodule

// File: tb/test_ata_taskfile_regs.sv
module test_ata_taskfile_regs;

    localparam int K_RDATA = 0;
    localparam int K_IRQ   = 1;
    localparam int K_START = 2;
    localparam int K_CODE  = 3;
    localparam int K_LBA   = 4;
    localparam int K_SRST  = 5;
    localparam int K_NIEN  = 6;
    localparam int K_LMODE = 7;

    typedef struct {
        int          due;
        int          kind;
        logic [27:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_cmd = 1'b0, cs_ctl = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cmd_done = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        cmd_start, irq, soft_rst, int_disable, lba_mode;
    logic [7:0]  cmd_code;
    logic [27:0] lba;

    int cyc = 0;
    int t_drv = 0;
    int n_checks = 0;
    int n_fail = 0;
    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ata_taskfile_regs #(.DEV_ID(0)) i_ata_taskfile_regs (
        .clk(clk), .rst(rst), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .cmd_done(cmd_done), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .irq(irq), .soft_rst(soft_rst), .int_disable(int_disable),
        .lba(lba), .lba_mode(lba_mode)
    );

    function automatic logic [27:0] observe(input int kind);
        case (kind)
            K_RDATA: return 28'(rdata);
            K_IRQ:   return 28'(irq);
            K_START: return 28'(cmd_start);
            K_CODE:  return 28'(cmd_code);
            K_LBA:   return lba;
            K_SRST:  return 28'(soft_rst);
            K_NIEN:  return 28'(int_disable);
            default: return 28'(lba_mode);
        endcase
    endfunction

    // monitor: compares every expected item in the cycle it is due
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                logic [27:0] act;
                act = observe(sb[i].kind);
                n_checks++;
                if (sb[i].due < cyc) begin
                    n_fail++;
                    $display("FAIL %s kind %0d missed its cycle, expected %0h", sb[i].req, sb[i].kind, sb[i].exp);
                end else if (act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s kind %0d cycle %0d actual %0h expected %0h",
                             sb[i].req, sb[i].kind, cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int d, input int kind, input logic [27:0] v, input string req);
        item_t it;
        it.due = t_drv + d; it.kind = kind; it.exp = v; it.req = req;
        sb.push_back(it);
    endtask

    task automatic drive(input logic c_cmd, input logic c_ctl, input logic [2:0] a,
                         input logic w, input logic r, input logic [15:0] d, input logic dn);
        @(posedge clk); #1;
        cs_cmd = c_cmd; cs_ctl = c_ctl; addr = a; wr_en = w; rd_en = r; wdata = d; cmd_done = dn;
        t_drv = cyc;
    endtask

    task automatic rel();
        @(posedge clk); #1;
        cs_cmd = 0; cs_ctl = 0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0; cmd_done = 0;
    endtask

    task automatic wcb(input logic [2:0] a, input logic [15:0] d);
        drive(1, 0, a, 1, 0, d, 0); rel();
    endtask

    task automatic wctl(input logic [7:0] d);
        drive(0, 1, 3'd2, 1, 0, {8'h00, d}, 0); rel();
    endtask

    task automatic rcb(input logic [2:0] a, input logic [15:0] v, input string req);
        drive(1, 0, a, 0, 1, '0, 0); expect_at(0, K_RDATA, 28'(v), req); rel();
    endtask

    task automatic ralt(input logic [15:0] v, input string req);
        drive(0, 1, 3'd2, 0, 1, '0, 0); expect_at(0, K_RDATA, 28'(v), req); rel();
    endtask

    task automatic done_pulse();
        drive(0, 0, 3'd0, 0, 0, '0, 1); rel();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;

        // R1 reset values
        drive(1, 0, 3'd7, 0, 1, '0, 0);
        expect_at(0, K_RDATA, 28'h50, "R1");
        expect_at(0, K_IRQ, 0, "R1");
        expect_at(0, K_SRST, 0, "R1");
        expect_at(0, K_NIEN, 0, "R1");
        expect_at(0, K_LBA, 28'h1, "R1");
        rel();
        rcb(3'd2, 16'h1, "R1");
        rcb(3'd3, 16'h1, "R1");
        rcb(3'd4, 16'h0, "R1");
        rcb(3'd0, 16'h0, "R1");
        rcb(3'd6, 16'h0, "R1");

        // R2 / R3 register map and LBA
        wcb(3'd3, 16'h0034);
        wcb(3'd4, 16'h0056);
        wcb(3'd5, 16'h0078);
        wcb(3'd6, 16'h00E9);
        expect_at(1, K_LBA, 28'h9785634, "R3");
        expect_at(1, K_LMODE, 1, "R3");
        wcb(3'd6, 16'h00A9);
        expect_at(1, K_LMODE, 0, "R3");
        rcb(3'd6, 16'h00A9, "R2");
        rcb(3'd5, 16'h0078, "R2");
        wcb(3'd0, 16'hBEEF);
        rcb(3'd0, 16'hBEEF, "R2");
        wcb(3'd1, 16'h00AA);
        rcb(3'd1, 16'h0000, "R2");
        wcb(3'd2, 16'h01FF);
        rcb(3'd2, 16'h00FF, "R2");

        // R5 command start
        wcb(3'd7, 16'h00C8);
        expect_at(1, K_START, 1, "R5");
        expect_at(1, K_CODE, 28'hC8, "R5");
        expect_at(2, K_START, 0, "R5");
        ralt(16'h0080, "R5");
        wcb(3'd7, 16'h0020);
        expect_at(1, K_START, 0, "R5");
        expect_at(1, K_CODE, 28'hC8, "R5");

        // R6 / R7 / R8 completion and interrupt
        done_pulse();
        expect_at(1, K_IRQ, 1, "R7");
        drive(0, 1, 3'd2, 0, 1, '0, 0);
        expect_at(0, K_RDATA, 28'h50, "R6");
        rel();
        expect_at(1, K_IRQ, 1, "R8");
        rcb(3'd7, 16'h0050, "R8");
        expect_at(1, K_IRQ, 0, "R8");
        done_pulse();
        expect_at(1, K_IRQ, 0, "R6");
        rcb(3'd7, 16'h0050, "R6");

        // R9 / R7 interrupt disabled
        wctl(8'h02);
        expect_at(1, K_NIEN, 1, "R9");
        expect_at(1, K_SRST, 0, "R9");
        wcb(3'd7, 16'h00EC);
        done_pulse();
        expect_at(1, K_IRQ, 0, "R7");
        ralt(16'h0050, "R6");
        wctl(8'h00);
        expect_at(1, K_NIEN, 0, "R9");

        // R4 device selection gating
        wcb(3'd6, 16'h00F0);
        rcb(3'd3, 16'h0000, "R4");
        ralt(16'h0000, "R4");
        wcb(3'd3, 16'h0011);
        wcb(3'd7, 16'h0030);
        expect_at(1, K_START, 0, "R4");
        wctl(8'h02);
        expect_at(1, K_NIEN, 1, "R4");
        wctl(8'h00);
        wcb(3'd6, 16'h00E0);
        rcb(3'd3, 16'h0034, "R4");
        ralt(16'h0050, "R4");

        // R10 soft reset
        wcb(3'd5, 16'h0012);
        wcb(3'd7, 16'h0091);
        done_pulse();
        expect_at(1, K_IRQ, 1, "R7");
        wctl(8'h04);
        expect_at(1, K_SRST, 1, "R9");
        expect_at(1, K_IRQ, 0, "R10");
        ralt(16'h0080, "R10");
        done_pulse();
        ralt(16'h0080, "R10");
        wctl(8'h00);
        expect_at(1, K_SRST, 0, "R10");
        expect_at(1, K_LBA, 28'h1, "R10");
        rcb(3'd7, 16'h0050, "R10");
        rcb(3'd5, 16'h0000, "R10");
        rcb(3'd3, 16'h0001, "R10");
        rcb(3'd2, 16'h0001, "R10");
        rcb(3'd0, 16'h0000, "R10");

        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            n_fail++; n_checks++;
            $display("FAIL scoreboard left %0d items, expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule